// File: doc/BRIEF.md
# Blit Copy Command Packet Decoder

This block sits in front of a 2D copy engine and turns a stream of 32-bit command words into one copy descriptor per packet. Each packet describes a rectangle of 32-bit pixels to move from a source surface to a destination surface. The decoder checks the header word, collects the address, pitch, size and tiling fields that follow it, and presents them as a single descriptor. Two packet families are understood: a fast-copy packet that is always 10 words long, and a legacy packet that is 8 words long with 32-bit addresses or 10 words long with 64-bit addresses. A batch-end word is consumed silently.

Words enter on a valid/ready stream. A word transfers on a rising clock edge where `in_valid` and `in_ready` are both high. The descriptor leaves on a second valid/ready pair. Once `desc_valid` is raised, it and every descriptor field stay fixed until the edge where `desc_ready` is high. For that whole time `in_ready` is low, so the producer stalls. Pitches are always reported in bytes, whatever unit the packet used. A malformed header yields a descriptor that carries an error flag. The words the header declared are then skipped, so decoding picks up again at the next header.

Top module: `blit_cmd_decoder`

## Requirements
- R1: After reset, `desc_valid` is 0 and `in_ready` is 1.
- R2: A header with opcode 0x42 in bits 31:24 and 8 in bits 7:0 starts a fast-copy packet of 10 words. The words are: header; flags word (destination pitch in bits 15:0); ignored; height in bits 31:16 with width in bits 15:0; destination address low; destination address high; ignored; source pitch in bits 15:0; source address low; source address high. These fields appear on the descriptor with `desc_fmt`=0.
- R3: In a fast-copy packet, the pitch of a linear surface is taken as bytes and reported as is. The pitch of any tiled surface is taken as dwords and reported multiplied by 4.
- R4: In a fast-copy header, bits 21:20 give the source tile mode and bits 17:16 the destination tile mode (0 linear, 1 X-major, 2 Y-major). In the flags word, bit 29 marks the source and bit 30 marks the destination as the second-generation tile format. The reported tile code is 0 linear, 1 X-major, 2 Y-major, or 3 when the mode is Y-major and the matching flag is set.
- R5: A header with opcode 0x53 and 6 in bits 7:0 starts an 8-word legacy packet. Its words are: header; flags word with destination pitch; ignored; size; destination address; ignored; source pitch; source address. The address high halves are reported as 0 and `desc_fmt` is 1. Header bit 15 marks the source as tiled and bit 11 marks the destination as tiled. A tiled surface reports tile code 1 and four times the given pitch. An untiled surface reports code 0 and the pitch as given.
- R6: A legacy header with 8 in bits 7:0 starts a 10-word legacy packet in which each address word is followed by its high word.
- R7: A header is malformed if it has an unknown opcode, a length that is not allowed for its opcode, or a fast-copy tile mode of 3. The next cycle it yields a descriptor with `desc_err`=1 and all size and address fields 0. After that descriptor is accepted, the next (bits 7:0)+1 words are consumed without effect, and the word after them is decoded as a header.
- R8: A batch-end word (opcode 0x05) is consumed and produces no descriptor. The following word is decoded as a header.
- R9: A well-formed packet with width 0 or height 0 yields a descriptor with `desc_empty`=1. Otherwise `desc_empty` is 0.
- R10: While `desc_valid` is high and `desc_ready` is low, `desc_valid` and all descriptor fields hold, and `in_ready` is 0.
- R11: The words in the ignored positions have no effect on any descriptor field.
- R12: `desc_valid` rises on the clock edge that accepts the last word of a packet or a malformed header, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Decoder can take a word |
| in_data | input | 32 | Command word |
| desc_valid | output | 1 | Descriptor pending |
| desc_ready | input | 1 | Copy engine accepts descriptor |
| desc_err | output | 1 | Descriptor reports a malformed header |
| desc_empty | output | 1 | Rectangle has zero width or height |
| desc_fmt | output | 1 | 0 fast-copy, 1 legacy packet |
| desc_src_tile | output | 2 | Source tile code |
| desc_dst_tile | output | 2 | Destination tile code |
| desc_src_addr | output | 64 | Source address |
| desc_dst_addr | output | 64 | Destination address |
| desc_src_pitch | output | PITCH_W+2 | Source pitch in bytes |
| desc_dst_pitch | output | PITCH_W+2 | Destination pitch in bytes |
| desc_width | output | DIM_W | Rectangle width in pixels |
| desc_height | output | DIM_W | Rectangle height in pixels |

## Verification
If the word index drifts, or the 8-word remap is wrong, a field is loaded from the wrong word. This shows up on the descriptor of that same packet, for example as an address high half that is not 0 or a width taken from an ignored word. A wrong skip count is only seen after the following packet: the next header is either swallowed or mistaken for data, so the next descriptor is missing, flagged as an error, or garbled. A decoder stuck in its pending state shows at once as `in_ready` staying low after `desc_ready`.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;
  localparam int unsigned SLOT_W = 4;

  typedef enum logic [1:0] {
    TILE_LIN = 2'd0,
    TILE_X   = 2'd1,
    TILE_Y   = 2'd2,
    TILE_4   = 2'd3
  } tile_e;

  typedef enum logic [2:0] {
    PK_END  = 3'd0,
    PK_FAST = 3'd1,
    PK_L32  = 3'd2,
    PK_L64  = 3'd3,
    PK_BAD  = 3'd4
  } pkt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_HOLD = 2'd2,
    ST_SKIP = 2'd3
  } seq_st_e;

  localparam logic [7:0] OP_FAST   = 8'h42;
  localparam logic [7:0] OP_LEGACY = 8'h53;
  localparam logic [7:0] OP_END    = 8'h05;

  localparam int unsigned FAST_WORDS  = 10;
  localparam int unsigned LEG32_WORDS = 8;
  localparam int unsigned LEG64_WORDS = 10;

  // canonical word slots (10-word layout); the 8-word layout is remapped onto these
  localparam logic [SLOT_W-1:0] SL_FLAGS  = 4'd1;
  localparam logic [SLOT_W-1:0] SL_SIZE   = 4'd3;
  localparam logic [SLOT_W-1:0] SL_DLO    = 4'd4;
  localparam logic [SLOT_W-1:0] SL_DHI    = 4'd5;
  localparam logic [SLOT_W-1:0] SL_SPITCH = 4'd7;
  localparam logic [SLOT_W-1:0] SL_SLO    = 4'd8;
  localparam logic [SLOT_W-1:0] SL_SHI    = 4'd9;
  localparam logic [SLOT_W-1:0] SL_REMAP  = 4'd5;

  localparam int unsigned SRC_T4_BIT = 29;
  localparam int unsigned DST_T4_BIT = 30;
endpackage

// File: rtl/bcd_hdr_decode.sv
`timescale 1ns/1ps
module bcd_hdr_decode
  import bcd_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic [7:0]       opcode,
  input  logic [1:0]       fast_smode,
  input  logic [1:0]       fast_dmode,
  input  logic             leg_s_tiled,
  input  logic             leg_d_tiled,
  input  logic [LEN_W-1:0] len,
  output pkt_e             kind,
  output tile_e            s_base,
  output tile_e            d_base
);
  localparam logic [LEN_W-1:0] FAST_LEN  = LEN_W'(FAST_WORDS - 2);
  localparam logic [LEN_W-1:0] LEG32_LEN = LEN_W'(LEG32_WORDS - 2);
  localparam logic [LEN_W-1:0] LEG64_LEN = LEN_W'(LEG64_WORDS - 2);

  logic fast_modes_ok;
  assign fast_modes_ok = (fast_smode != 2'b11) && (fast_dmode != 2'b11);

  always_comb begin
    kind   = PK_BAD;
    s_base = TILE_LIN;
    d_base = TILE_LIN;
    case (opcode)
      OP_END: kind = PK_END;
      OP_FAST: begin
        if (len == FAST_LEN && fast_modes_ok) begin
          kind   = PK_FAST;
          s_base = tile_e'(fast_smode);
          d_base = tile_e'(fast_dmode);
        end
      end
      OP_LEGACY: begin
        if (len == LEG32_LEN || len == LEG64_LEN) begin
          kind   = (len == LEG32_LEN) ? PK_L32 : PK_L64;
          s_base = leg_s_tiled ? TILE_X : TILE_LIN;
          d_base = leg_d_tiled ? TILE_X : TILE_LIN;
        end
      end
      default: kind = PK_BAD;
    endcase
  end
endmodule

// File: rtl/bcd_seq.sv
`timescale 1ns/1ps
module bcd_seq
  import bcd_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  pkt_e              kind,
  input  logic [LEN_W-1:0]  len,
  input  logic              desc_ready,
  output logic              in_ready,
  output logic              desc_valid,
  output logic              desc_err,
  output logic              st_idle,
  output logic              hdr_take,
  output logic              hdr_bad,
  output logic              word_take,
  output logic [SLOT_W-1:0] slot
);
  localparam int CNT_W = LEN_W + 1;

  seq_st_e          st;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] skip;
  logic             leg32;
  logic             err_q;
  logic             fire;
  logic             is_pkt;
  logic [CNT_W-1:0] span;

  assign in_ready  = (st != ST_HOLD);
  assign fire      = in_valid && in_ready;
  assign is_pkt    = (kind == PK_FAST) || (kind == PK_L32) || (kind == PK_L64);
  assign span      = {1'b0, len} + CNT_W'(1);
  assign hdr_take  = fire && (st == ST_IDLE) && is_pkt;
  assign hdr_bad   = fire && (st == ST_IDLE) && (kind == PK_BAD);
  assign word_take = fire && (st == ST_BODY);
  assign slot      = (leg32 && idx >= CNT_W'(SL_REMAP)) ? SLOT_W'(idx + CNT_W'(1))
                                                        : SLOT_W'(idx);
  assign desc_valid = (st == ST_HOLD);
  assign desc_err   = err_q;
  assign st_idle    = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      idx   <= '0;
      last  <= '0;
      skip  <= '0;
      leg32 <= 1'b0;
      err_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (fire) begin
            if (is_pkt) begin
              st    <= ST_BODY;
              idx   <= CNT_W'(1);
              last  <= span;
              leg32 <= (kind == PK_L32);
              err_q <= 1'b0;
            end else if (kind == PK_BAD) begin
              st    <= ST_HOLD;
              err_q <= 1'b1;
              skip  <= span;
            end
          end
        end
        ST_BODY: begin
          if (fire) begin
            if (idx == last) begin
              st   <= ST_HOLD;
              skip <= '0;
            end else begin
              idx <= idx + CNT_W'(1);
            end
          end
        end
        ST_HOLD: begin
          if (desc_ready) st <= (skip != '0) ? ST_SKIP : ST_IDLE;
        end
        ST_SKIP: begin
          if (fire) begin
            skip <= skip - CNT_W'(1);
            if (skip == CNT_W'(1)) st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bcd_surface.sv
`timescale 1ns/1ps
module bcd_surface
  import bcd_pkg::*;
#(
  parameter int                PITCH_W    = 16,
  parameter logic [SLOT_W-1:0] SLOT_PITCH = SL_SPITCH,
  parameter logic [SLOT_W-1:0] SLOT_LO    = SL_SLO,
  parameter logic [SLOT_W-1:0] SLOT_HI    = SL_SHI,
  parameter int                T4_BIT     = 29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  tile_e              base_in,
  input  logic               t4_en,
  input  logic               word_take,
  input  logic [SLOT_W-1:0]  slot,
  input  logic [31:0]        word,
  output logic [1:0]         tile,
  output logic [PITCH_W+1:0] pitch,
  output logic [63:0]        addr
);
  tile_e              base_q;
  tile_e              eff;
  logic               t4_q;
  logic [PITCH_W-1:0] praw;
  logic [31:0]        lo_q;
  logic [31:0]        hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= TILE_LIN;
      t4_q   <= 1'b0;
      praw   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (clear) begin
      base_q <= base_in;
      t4_q   <= 1'b0;
      praw   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (word_take) begin
      if (slot == SLOT_PITCH)          praw <= word[PITCH_W-1:0];
      if (slot == SL_FLAGS && t4_en)   t4_q <= word[T4_BIT];
      if (slot == SLOT_LO)             lo_q <= word;
      if (slot == SLOT_HI)             hi_q <= word;
    end
  end

  assign eff   = (base_q == TILE_Y && t4_q) ? TILE_4 : base_q;
  assign tile  = eff;
  assign pitch = (eff == TILE_LIN) ? {2'b00, praw} : {praw, 2'b00};
  assign addr  = {hi_q, lo_q};
endmodule

// File: rtl/blit_cmd_decoder.sv
`timescale 1ns/1ps
module blit_cmd_decoder
  import bcd_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int PITCH_W = 16,
  parameter int DIM_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_data,
  output logic               desc_valid,
  input  logic               desc_ready,
  output logic               desc_err,
  output logic               desc_empty,
  output logic               desc_fmt,
  output logic [1:0]         desc_src_tile,
  output logic [1:0]         desc_dst_tile,
  output logic [63:0]        desc_src_addr,
  output logic [63:0]        desc_dst_addr,
  output logic [PITCH_W+1:0] desc_src_pitch,
  output logic [PITCH_W+1:0] desc_dst_pitch,
  output logic [DIM_W-1:0]   desc_width,
  output logic [DIM_W-1:0]   desc_height
);
  localparam int NSIDE = 2;

  pkt_e              kind;
  tile_e             base_a [NSIDE];
  logic              st_idle;
  logic              hdr_take;
  logic              hdr_bad;
  logic              word_take;
  logic              clear;
  logic [SLOT_W-1:0] slot;
  logic              fmt_q;
  logic [DIM_W-1:0]  w_q;
  logic [DIM_W-1:0]  h_q;
  logic [1:0]         tile_a  [NSIDE];
  logic [PITCH_W+1:0] pitch_a [NSIDE];
  logic [63:0]        addr_a  [NSIDE];

  bcd_hdr_decode #(.LEN_W(LEN_W)) u_hdr (
    .opcode      (in_data[31:24]),
    .fast_smode  (in_data[21:20]),
    .fast_dmode  (in_data[17:16]),
    .leg_s_tiled (in_data[15]),
    .leg_d_tiled (in_data[11]),
    .len         (in_data[LEN_W-1:0]),
    .kind        (kind),
    .s_base      (base_a[0]),
    .d_base      (base_a[1])
  );

  bcd_seq #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .kind       (kind),
    .len        (in_data[LEN_W-1:0]),
    .desc_ready (desc_ready),
    .in_ready   (in_ready),
    .desc_valid (desc_valid),
    .desc_err   (desc_err),
    .st_idle    (st_idle),
    .hdr_take   (hdr_take),
    .hdr_bad    (hdr_bad),
    .word_take  (word_take),
    .slot       (slot)
  );

  assign clear = hdr_take || hdr_bad;

  // index 0 = source surface, index 1 = destination surface
  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    localparam logic [SLOT_W-1:0] SP = (g == 0) ? SL_SPITCH : SL_FLAGS;
    localparam logic [SLOT_W-1:0] SL = (g == 0) ? SL_SLO    : SL_DLO;
    localparam logic [SLOT_W-1:0] SH = (g == 0) ? SL_SHI    : SL_DHI;
    localparam int                TB = (g == 0) ? SRC_T4_BIT : DST_T4_BIT;
    bcd_surface #(
      .PITCH_W    (PITCH_W),
      .SLOT_PITCH (SP),
      .SLOT_LO    (SL),
      .SLOT_HI    (SH),
      .T4_BIT     (TB)
    ) u_surf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .base_in   (base_a[g]),
      .t4_en     (!fmt_q),
      .word_take (word_take),
      .slot      (slot),
      .word      (in_data),
      .tile      (tile_a[g]),
      .pitch     (pitch_a[g]),
      .addr      (addr_a[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= 1'b0;
      w_q   <= '0;
      h_q   <= '0;
    end else if (clear) begin
      fmt_q <= hdr_take && (kind != PK_FAST);
      w_q   <= '0;
      h_q   <= '0;
    end else if (word_take && slot == SL_SIZE) begin
      w_q <= in_data[DIM_W-1:0];
      h_q <= in_data[16+DIM_W-1:16];
    end
  end

  assign desc_fmt       = fmt_q;
  assign desc_width     = w_q;
  assign desc_height    = h_q;
  assign desc_empty     = !desc_err && (w_q == '0 || h_q == '0);
  assign desc_src_tile  = tile_a[0];
  assign desc_dst_tile  = tile_a[1];
  assign desc_src_pitch = pitch_a[0];
  assign desc_dst_pitch = pitch_a[1];
  assign desc_src_addr  = addr_a[0];
  assign desc_dst_addr  = addr_a[1];
endmodule

// File: rtl/bcd_checker.sv
`timescale 1ns/1ps
module bcd_checker
  import bcd_pkg::*;
#(
  parameter int PITCH_W = 16,
  parameter int DIM_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [31:0]        in_data,
  input logic               desc_valid,
  input logic               desc_ready,
  input logic               desc_err,
  input logic               desc_fmt,
  input logic [1:0]         desc_src_tile,
  input logic [1:0]         desc_dst_tile,
  input logic [PITCH_W+1:0] desc_src_pitch,
  input logic [63:0]        desc_src_addr,
  input logic [DIM_W-1:0]   desc_width,
  input logic [DIM_W-1:0]   desc_height,
  input logic               st_idle
);
  AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> !in_ready); // R10

  AST_DESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_src_addr) && $stable(desc_width)
      && $stable(desc_height) && $stable(desc_src_pitch) && $stable(desc_err))); // R10

  AST_LEGACY_TILE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_fmt) |-> (desc_src_tile <= 2'd1 && desc_dst_tile <= 2'd1)); // R5

  AST_END_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && st_idle && in_data[31:24] == OP_END) |=> !desc_valid); // R8

  AST_ERR_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_err) |-> (desc_width == '0 && desc_height == '0 && desc_src_addr == '0)); // R7

  AST_RISE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desc_valid) |-> $past(in_valid && in_ready)); // R12
endmodule

bind blit_cmd_decoder bcd_checker #(.PITCH_W(PITCH_W), .DIM_W(DIM_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_data        (in_data),
  .desc_valid     (desc_valid),
  .desc_ready     (desc_ready),
  .desc_err       (desc_err),
  .desc_fmt       (desc_fmt),
  .desc_src_tile  (desc_src_tile),
  .desc_dst_tile  (desc_dst_tile),
  .desc_src_pitch (desc_src_pitch),
  .desc_src_addr  (desc_src_addr),
  .desc_width     (desc_width),
  .desc_height    (desc_height),
  .st_idle        (st_idle)
);

// File: tb/blit_cmd_decoder_tb.sv
`timescale 1ns/1ps
module blit_cmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        desc_valid;
  logic        desc_ready = 1'b0;
  logic        desc_err, desc_empty, desc_fmt;
  logic [1:0]  desc_src_tile, desc_dst_tile;
  logic [63:0] desc_src_addr, desc_dst_addr;
  logic [17:0] desc_src_pitch, desc_dst_pitch;
  logic [15:0] desc_width, desc_height;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [31:0] JUNK    = 32'hDEAD_BEEF;
  localparam logic [31:0] END_W   = 32'h0500_0000;
  localparam logic [31:0] FAST_OK = 32'h4200_0008;

  blit_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_err(desc_err), .desc_empty(desc_empty),
    .desc_fmt(desc_fmt), .desc_src_tile(desc_src_tile), .desc_dst_tile(desc_dst_tile),
    .desc_src_addr(desc_src_addr), .desc_dst_addr(desc_dst_addr),
    .desc_src_pitch(desc_src_pitch), .desc_dst_pitch(desc_dst_pitch),
    .desc_width(desc_width), .desc_height(desc_height)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the word transferred
  task automatic send(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
  endtask

  task automatic take();
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0;
  endtask

  function automatic logic [31:0] fast_hdr(input logic [1:0] sm, input logic [1:0] dm);
    return {8'h42, 2'b00, sm, 2'b00, dm, 8'h00, 8'd8};
  endfunction

  task automatic send_fast(input logic [1:0] sm, dm, input bit s4, d4,
                           input logic [15:0] sp, dp, w, h, input logic [63:0] sa, da);
    send(fast_hdr(sm, dm));
    send({1'b0, d4, s4, 3'b000, 2'b11, 8'h00, dp});
    send(JUNK);
    send({h, w});
    send(da[31:0]);
    send(da[63:32]);
    send(JUNK);
    send({16'h0000, sp});
    send(sa[31:0]);
    send(sa[63:32]);
  endtask

  task automatic send_leg(input bit wide, st, dt, input logic [15:0] sp, dp, w, h,
                          input logic [63:0] sa, da);
    send({8'h53, 8'h00, st, 3'b000, dt, 3'b000, wide ? 8'd8 : 8'd6});
    send({6'b0, 2'b11, 8'hCC, dp});
    send(JUNK);
    send({h, w});
    send(da[31:0]);
    if (wide) send(da[63:32]);
    send(JUNK);
    send({16'h0000, sp});
    send(sa[31:0]);
    if (wide) send(sa[63:32]);
  endtask

  task automatic expect_desc(input string tag, input bit err, empty, fmt,
                             input logic [1:0] st, dt, input logic [17:0] sp, dp,
                             input logic [15:0] w, h, input logic [63:0] sa, da);
    chk({tag, " valid"}, 64'(desc_valid), 64'd1);
    chk({tag, " err"}, 64'(desc_err), 64'(err));
    chk({tag, " empty"}, 64'(desc_empty), 64'(empty));
    chk({tag, " fmt"}, 64'(desc_fmt), 64'(fmt));
    chk({tag, " stile"}, 64'(desc_src_tile), 64'(st));
    chk({tag, " dtile"}, 64'(desc_dst_tile), 64'(dt));
    chk({tag, " spitch"}, 64'(desc_src_pitch), 64'(sp));
    chk({tag, " dpitch"}, 64'(desc_dst_pitch), 64'(dp));
    chk({tag, " width"}, 64'(desc_width), 64'(w));
    chk({tag, " height"}, 64'(desc_height), 64'(h));
    chk({tag, " saddr"}, desc_src_addr, sa);
    chk({tag, " daddr"}, desc_dst_addr, da);
  endtask

  task automatic t_reset();
    chk("R1 desc_valid after reset", 64'(desc_valid), 64'd0);
    chk("R1 in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_fast_linear();
    send_fast(2'd0, 2'd0, 1'b0, 1'b0, 16'h0100, 16'h0200, 16'd64, 16'd32,
              64'h0000_0012_3456_7000, 64'h0000_00AB_CDEF_1000);
    // R12: descriptor visible right after the last word; R2/R3/R11 field values
    expect_desc("R2 R3 R11 R12 fast linear", 0, 0, 0, 2'd0, 2'd0, 18'h0100, 18'h0200,
                16'd64, 16'd32, 64'h0000_0012_3456_7000, 64'h0000_00AB_CDEF_1000);
    take();
    chk("R10 released after accept", 64'(desc_valid), 64'd0);
  endtask

  task automatic t_fast_tiled();
    send_fast(2'd1, 2'd2, 1'b0, 1'b1, 16'h0040, 16'h0080, 16'd128, 16'd16,
              64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    expect_desc("R3 R4 fast X src tile4 dst", 0, 0, 0, 2'd1, 2'd3, 18'h0100, 18'h0200,
                16'd128, 16'd16, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    take();
  endtask

  task automatic t_fast_ymajor();
    send_fast(2'd2, 2'd1, 1'b0, 1'b0, 16'h0010, 16'h0020, 16'd8, 16'd4,
              64'h0000_0000_0000_A000, 64'h0000_0000_0000_B000);
    expect_desc("R4 fast Y src X dst", 0, 0, 0, 2'd2, 2'd1, 18'h0040, 18'h0080,
                16'd8, 16'd4, 64'h0000_0000_0000_A000, 64'h0000_0000_0000_B000);
    take();
  endtask

  task automatic t_legacy_narrow();
    send_leg(1'b0, 1'b1, 1'b0, 16'h0080, 16'h0400, 16'd256, 16'd8,
             64'hFFFF_0000_2000_0000, 64'hFFFF_0000_3000_0000);
    expect_desc("R5 R11 legacy 8-word", 0, 0, 1, 2'd1, 2'd0, 18'h0200, 18'h0400,
                16'd256, 16'd8, 64'h0000_0000_2000_0000, 64'h0000_0000_3000_0000);
    take();
  endtask

  task automatic t_legacy_wide();
    send_leg(1'b1, 1'b0, 1'b1, 16'h0300, 16'h0050, 16'd100, 16'd200,
             64'h0000_0007_0000_1000, 64'h0000_0009_0000_2000);
    expect_desc("R6 legacy 10-word", 0, 0, 1, 2'd0, 2'd1, 18'h0300, 18'h0140,
                16'd100, 16'd200, 64'h0000_0007_0000_1000, 64'h0000_0009_0000_2000);
    take();
  endtask

  task automatic t_backpressure();
    send_fast(2'd0, 2'd0, 1'b0, 1'b0, 16'h0010, 16'h0010, 16'd5, 16'd6,
              64'h0000_0000_0000_0100, 64'h0000_0000_0000_0200);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 valid held", 64'(desc_valid), 64'd1);
      chk("R10 input stalled", 64'(in_ready), 64'd0);
      chk("R10 width held", 64'(desc_width), 64'd5);
      chk("R10 addr held", desc_src_addr, 64'h0000_0000_0000_0100);
    end
    take();
    chk("R10 ready again", 64'(in_ready), 64'd1);
  endtask

  task automatic skip_then_good(input string tag, input int n);
    take();
    for (int i = 0; i < n; i++) send(FAST_OK);
    chk({tag, " no desc after skip"}, 64'(desc_valid), 64'd0);
    chk({tag, " ready after skip"}, 64'(in_ready), 64'd1);
    send_fast(2'd0, 2'd0, 1'b0, 1'b0, 16'h0020, 16'h0030, 16'd7, 16'd9,
              64'h0000_0000_0000_0400, 64'h0000_0000_0000_0800);
    expect_desc({tag, " resync"}, 0, 0, 0, 2'd0, 2'd0, 18'h0020, 18'h0030,
                16'd7, 16'd9, 64'h0000_0000_0000_0400, 64'h0000_0000_0000_0800);
    take();
  endtask

  task automatic t_bad_length();
    send(32'h4200_0005);
    expect_desc("R7 bad length", 1, 0, 0, 2'd0, 2'd0, 18'h0, 18'h0, 16'd0, 16'd0, 64'h0, 64'h0);
    skip_then_good("R7 bad length", 6);
  endtask

  task automatic t_bad_opcode();
    send(32'h7700_0002);
    expect_desc("R7 unknown opcode", 1, 0, 0, 2'd0, 2'd0, 18'h0, 18'h0, 16'd0, 16'd0, 64'h0, 64'h0);
    skip_then_good("R7 unknown opcode", 3);
  endtask

  task automatic t_reserved_mode();
    send(fast_hdr(2'd3, 2'd0));
    chk("R7 reserved mode err", 64'(desc_err), 64'd1);
    chk("R7 reserved mode valid", 64'(desc_valid), 64'd1);
    skip_then_good("R7 reserved mode", 9);
  endtask

  task automatic t_batch_end();
    send(END_W);
    chk("R8 no desc for end", 64'(desc_valid), 64'd0);
    chk("R8 ready after end", 64'(in_ready), 64'd1);
    send_leg(1'b0, 1'b0, 1'b0, 16'h0040, 16'h0040, 16'd3, 16'd3,
             64'h0000_0000_0000_0010, 64'h0000_0000_0000_0020);
    expect_desc("R8 header after end", 0, 0, 1, 2'd0, 2'd0, 18'h0040, 18'h0040,
                16'd3, 16'd3, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0020);
    take();
  endtask

  task automatic t_empty();
    send_fast(2'd0, 2'd0, 1'b0, 1'b0, 16'h0010, 16'h0010, 16'd0, 16'd12,
              64'h0000_0000_0000_0100, 64'h0000_0000_0000_0200);
    chk("R9 zero width empty", 64'(desc_empty), 64'd1);
    chk("R9 zero width no err", 64'(desc_err), 64'd0);
    take();
    send_leg(1'b0, 1'b0, 1'b0, 16'h0010, 16'h0010, 16'd4, 16'd0,
             64'h0000_0000_0000_0100, 64'h0000_0000_0000_0200);
    chk("R9 zero height empty", 64'(desc_empty), 64'd1);
    take();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast_linear();
    t_fast_tiled();
    t_fast_ymajor();
    t_legacy_narrow();
    t_legacy_wide();
    t_backpressure();
    t_bad_length();
    t_bad_opcode();
    t_reserved_mode();
    t_batch_end();
    t_empty();
    finish_run();
  end
endmodule